// File: doc/BRIEF.md
# Translation Buffer with Not-Recently-Used Replacement

This block is a small, fully associative cache of address translations for 32-bit virtual addresses that use 4 KiB pages. Every entry stores a virtual page number and the physical frame that backs it. A requester presents an address with a read/write flag. The block compares the 20-bit page number against every valid entry in the same cycle. On a hit it returns the physical address, formed from the stored frame with the low 12 bits of the address copied through. On a miss it gives no translation. It raises a fault with the missing page number so that an external page walker can fetch the mapping, and the requester keeps its request asserted, stalled, until the translation shows up.

When the walker offers a new mapping, the block picks a slot. An empty slot is used first. Once every slot is full, the block applies a not-recently-used policy driven by per-entry reference bits. If the chosen victim was modified by a write, the block first sends its page and frame out on a writeback handshake, and it writes the new mapping only after memory takes the writeback. The stalled request then retries and hits.

Top module: `tlb_nru`

## Requirements
- R1: After reset every entry is invalid, so any request misses; `fill_ready` is 1 and `wb_valid` is 0.
- R2: On a hit, `req_paddr` combinationally equals {stored frame, `req_vaddr[11:0]`}, and `req_hit` is 1.
- R3: On a request with no valid matching entry, `req_hit` is 0 and `fault_valid` is 1, with `fault_vpn` = `req_vaddr[31:12]`.
- R4: While any entry is invalid, a new mapping goes into the lowest-index invalid entry, so it never displaces a valid entry.
- R5: A hit sets that entry's referenced bit. When all entries are valid, the victim is the lowest-index entry whose referenced bit is clear. A newly installed entry starts with its referenced bit clear.
- R6: When a victim is needed and every entry is referenced, all referenced bits are cleared first, so the victim is entry 0.
- R7: A hit with `req_write`=1 sets the entry's dirty bit. A read hit leaves the dirty bit alone, and a clean victim is replaced with no writeback.
- R8: A dirty victim raises `wb_valid` with its page and frame on `wb_vpn`/`wb_pfn`. These stay stable, and `fill_ready` stays 0, until `wb_ready` is seen high. The new entry is written on that accepting edge.
- R9: A clean victim, or a free slot, is written on the same edge that the fill is accepted (`fill_valid` and `fill_ready` both high).
- R10: Once a mapping is installed, a replayed request to that page hits.
- R11: While a writeback is pending, lookups neither hit nor fault. They produce no reference or dirty update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address |
| req_hit | output | 1 | Translation found |
| req_paddr | output | 32 | Physical address on hit |
| fault_valid | output | 1 | Miss, walk needed |
| fault_vpn | output | 20 | Page number that missed |
| fill_valid | input | 1 | Walker offers a mapping |
| fill_ready | output | 1 | Block can take a mapping |
| fill_vpn | input | 20 | Page number of new mapping |
| fill_pfn | input | 20 | Frame of new mapping |
| wb_valid | output | 1 | Dirty victim being written back |
| wb_ready | input | 1 | Memory accepts writeback |
| wb_vpn | output | 20 | Victim page number |
| wb_pfn | output | 20 | Victim frame |

## Verification
The bench fills all eight slots from reset and sweeps several offsets per page. It then drives a fixed run of hits, writes and fills whose victims can be computed by hand. This run covers the wrap where every slot is referenced, the case where only a middle slot is unreferenced, a dirty victim held for several cycles under backpressure, and a read-only victim. A design that cleared the wrong reference bits, or ignored them, would evict a different page, and a page expected to miss would still hit. A design that marked entries dirty on reads would emit an unexpected writeback. A design that installed before the writeback was accepted, or let lookups through during it, would show a hit or a moving writeback payload while the handshake is stalled.

// File: rtl/tlb_nru.sv
module tlb_nru #(
  parameter int N     = 8,
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   req_hit,
  output logic [PFN_W+OFF_W-1:0] req_paddr,
  output logic                   fault_valid,
  output logic [VA_W-OFF_W-1:0]  fault_vpn,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  output logic                   wb_valid,
  input  logic                   wb_ready,
  output logic [VA_W-OFF_W-1:0]  wb_vpn,
  output logic [PFN_W-1:0]       wb_pfn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld, rf, dty, vld_n, rf_n, dty_n;
  logic [VPN_W-1:0] tag [N];
  logic [PFN_W-1:0] frm [N];

  logic             busy;
  logic [IDX_W-1:0] pend_idx;
  logic [VPN_W-1:0] pend_vpn;
  logic [PFN_W-1:0] pend_pfn;

  logic             hit_any, free_any, nru_any;
  logic [IDX_W-1:0] hit_idx, free_idx, nru_idx, victim, ins_idx;
  logic [VPN_W-1:0] req_vpn;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  always_comb begin
    hit_any = 1'b0;  hit_idx  = '0;
    free_any = 1'b0; free_idx = '0;
    nru_any = 1'b0;  nru_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && tag[i] == req_vpn) begin
        hit_any = 1'b1; hit_idx = IDX_W'(i);
      end
      if (!vld[i]) begin
        free_any = 1'b1; free_idx = IDX_W'(i);
      end
      if (vld[i] && !rf[i]) begin
        nru_any = 1'b1; nru_idx = IDX_W'(i);
      end
    end
  end

  logic idle, accept, clear_all, vic_dirty, do_ins;

  assign idle       = !busy;
  assign accept     = fill_valid && idle;
  assign clear_all  = !free_any && !nru_any;
  assign victim     = free_any ? free_idx : (nru_any ? nru_idx : '0);
  assign vic_dirty  = vld[victim] && dty[victim];
  assign do_ins     = (accept && !vic_dirty) || (busy && wb_ready);
  assign ins_idx    = busy ? pend_idx : victim;

  assign req_hit     = req_valid && hit_any && idle;
  assign req_paddr   = req_hit ? {frm[hit_idx], req_vaddr[OFF_W-1:0]} : '0;
  assign fault_valid = req_valid && !hit_any && idle;
  assign fault_vpn   = req_vpn;
  assign fill_ready  = idle;
  assign wb_valid    = busy;
  assign wb_vpn      = tag[pend_idx];
  assign wb_pfn      = frm[pend_idx];

  always_comb begin
    vld_n = vld;
    rf_n  = rf;
    dty_n = dty;
    if (accept && clear_all) rf_n = '0;
    if (req_hit) begin
      rf_n[hit_idx] = 1'b1;
      if (req_write) dty_n[hit_idx] = 1'b1;
    end
    if (do_ins) begin
      vld_n[ins_idx] = 1'b1;
      rf_n[ins_idx]  = 1'b0;
      dty_n[ins_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      rf       <= '0;
      dty      <= '0;
      busy     <= 1'b0;
      pend_idx <= '0;
      pend_vpn <= '0;
      pend_pfn <= '0;
    end else begin
      vld <= vld_n;
      rf  <= rf_n;
      dty <= dty_n;
      if (accept && vic_dirty) begin
        busy     <= 1'b1;
        pend_idx <= victim;
        pend_vpn <= fill_vpn;
        pend_pfn <= fill_pfn;
      end else if (busy && wb_ready) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      tag[ins_idx] <= busy ? pend_vpn : fill_vpn;
      frm[ins_idx] <= busy ? pend_pfn : fill_pfn;
    end
  end
endmodule

// File: rtl/tlb_nru_chk.sv
module tlb_nru_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [VA_W-1:0]        req_vaddr,
  input logic                   req_hit,
  input logic [PFN_W+OFF_W-1:0] req_paddr,
  input logic                   fault_valid,
  input logic [VA_W-OFF_W-1:0]  fault_vpn,
  input logic                   fill_valid,
  input logic                   fill_ready,
  input logic [VA_W-OFF_W-1:0]  fill_vpn,
  input logic [PFN_W-1:0]       fill_pfn,
  input logic                   wb_valid,
  input logic                   wb_ready,
  input logic [VA_W-OFF_W-1:0]  wb_vpn,
  input logic [PFN_W-1:0]       wb_pfn
);
  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> req_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

  p_hit_xor_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> !fault_valid);

  p_fault_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (req_valid && fault_vpn == req_vaddr[VA_W-1:OFF_W]));

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_vpn) && $stable(wb_pfn)));

  p_fill_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !fill_ready);

  p_wb_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> !wb_valid);

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!req_hit && !fault_valid));
endmodule

bind tlb_nru tlb_nru_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_chk (.*);

// File: tb/sim_tlb_nru.sv
`timescale 1ns/1ps
module sim_tlb_nru;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_vaddr;
  logic        req_hit;
  logic [31:0] req_paddr;
  logic        fault_valid;
  logic [19:0] fault_vpn;
  logic        fill_valid, fill_ready;
  logic [19:0] fill_vpn, fill_pfn;
  logic        wb_valid, wb_ready;
  logic [19:0] wb_vpn, wb_pfn;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tlb_nru u0 (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pfn_of(input logic [19:0] vpn);
    return (vpn >= 20'h200) ? 20'hA000 + (vpn - 20'h200) : 20'h5000 + (vpn - 20'h100) * 20'h11;
  endfunction

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input bit wr,
                      input bit exp_hit, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = {vpn, off};
    #2;
    check(req_hit == exp_hit, req, req_hit, exp_hit);
    if (exp_hit)
      check(req_paddr == {pfn_of(vpn), off}, req, req_paddr, {pfn_of(vpn), off});
    else
      check(fault_valid && fault_vpn == vpn, req, {fault_valid, fault_vpn}, {1'b1, vpn});
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input string req);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn_of(vpn);
    #2;
    check(fill_ready, req, fill_ready, 1);
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; wb_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    @(negedge clk);
    check(fill_ready && !wb_valid, "R1", {fill_ready, wb_valid}, 2'b10);
    look(20'h100, 12'h000, 0, 0, "R1 R3");

    // R4 R10 R2: fill every slot, each replay hits, sweep offsets
    for (int i = 0; i < 8; i++) begin
      look(20'h100 + 20'(i), 12'h321, 0, 0, "R3");
      fill(20'h100 + 20'(i), "R9");
      look(20'h100 + 20'(i), 12'h000, 0, 1, "R10");
      look(20'h100 + 20'(i), 12'hFFF, 0, 1, "R2");
      look(20'h100 + 20'(i), 12'(i * 12'h155), 0, 1, "R2");
    end
    for (int i = 0; i < 8; i++) look(20'h100 + 20'(i), 12'h0A5, 0, 1, "R4");

    // R6: all referenced -> clear and evict slot 0 (0x100)
    fill(20'h200, "R6");
    look(20'h100, 12'h000, 0, 0, "R6");
    look(20'h102, 12'h010, 0, 1, "R5");
    look(20'h103, 12'h010, 0, 1, "R5");
    look(20'h101, 12'h010, 1, 1, "R7");
    // R5: slot 0 (0x200) is only unreferenced low slot
    fill(20'h201, "R5");
    look(20'h200, 12'h000, 0, 0, "R5");
    look(20'h201, 12'h004, 0, 1, "R10");
    // R5: slot 4 (0x104) is lowest unreferenced
    fill(20'h202, "R5");
    look(20'h104, 12'h000, 0, 0, "R5");
    look(20'h105, 12'h000, 0, 1, "R5");
    look(20'h202, 12'h000, 0, 1, "R10");
    look(20'h106, 12'h000, 0, 1, "R5");
    look(20'h107, 12'h000, 0, 1, "R5");
    // R6 again: wrap, evict slot 0 (0x201, clean)
    fill(20'h203, "R6");
    @(negedge clk);
    check(!wb_valid, "R7", wb_valid, 0);
    look(20'h201, 12'h000, 0, 0, "R6");
    look(20'h203, 12'h000, 0, 1, "R10");

    // R8: victim slot 1 (0x101) is dirty
    fill(20'h204, "R8");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(wb_valid, "R8", wb_valid, 1);
      check(wb_vpn == 20'h101 && wb_pfn == pfn_of(20'h101), "R8", {wb_vpn, wb_pfn}, {20'h101, pfn_of(20'h101)});
      check(!fill_ready, "R8", fill_ready, 0);
      req_valid = 1'b1; req_write = 1'b1; req_vaddr = {20'h102, 12'h0};
      #2;
      check(!req_hit && !fault_valid, "R11", {req_hit, fault_valid}, 0);
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
    end
    @(negedge clk);
    check(wb_valid, "R8", wb_valid, 1);
    wb_ready = 1'b1;
    @(posedge clk); #1;
    wb_ready = 1'b0;
    @(negedge clk);
    check(!wb_valid && fill_ready, "R8", {wb_valid, fill_ready}, 2'b01);
    look(20'h204, 12'h777, 0, 1, "R10");
    look(20'h101, 12'h000, 0, 0, "R8");

    // R7 R11: slot 2 (0x102) read only, stalled writes had no effect -> no writeback
    fill(20'h205, "R7");
    @(negedge clk);
    check(!wb_valid, "R7", wb_valid, 0);
    look(20'h102, 12'h000, 0, 0, "R7");
    look(20'h205, 12'h123, 0, 1, "R10");
    look(20'h103, 12'h000, 0, 1, "R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule